// File: doc/BRIEF.md
# Single-Bit and Scaled-Add Unit

A purely combinational 64-bit datapath slice that performs two families of integer operations. The first family manipulates one bit of an operand: it can set, clear or flip the addressed bit, or pull that bit out as a 0/1 result. The bit position comes either from a 6-bit immediate or from the low six bits of the second operand, chosen by a select flag.

The second family serves address generation. It scales the first operand by 2, 4 or 8 and adds the second operand. It also has unsigned-word variants, in which only the low 32 bits of the first operand count and are zero-extended first. A plain unsigned-word add and an unsigned-word left shift by the bit-position field complete the set. Every sum wraps modulo 2^64. The result follows the inputs in the same cycle. Decode and pipelining belong to the surrounding core.

Top module: `bitop_scaled_add`

## Requirements
- R1: The bit position is `imm_i` when `imm_sel_i` is 1 and `rs2_i[5:0]` when it is 0. Bits 63:6 of `rs2_i` never affect the position, so any position is taken modulo 64.
- R2: With `op_i` = 0 (set), the result is `rs1_i` with the addressed bit forced to 1.
- R3: With `op_i` = 1 (clear), the result is `rs1_i` with the addressed bit forced to 0.
- R4: With `op_i` = 2 (flip), the result is `rs1_i` with the addressed bit inverted and every other bit unchanged.
- R5: With `op_i` = 3 (extract), result bit 0 equals `rs1_i` at the addressed position and result bits 63:1 are 0.
- R6: With `op_i` = 4, 5 or 6, the result is (`rs1_i` << 1, 2 or 3 respectively) + `rs2_i`.
- R7: With `op_i` = 7, 8 or 9, the result is (zero-extended `rs1_i[31:0]` << 1, 2 or 3 respectively) + `rs2_i`.
- R8: With `op_i` = 10, the result is zero-extended `rs1_i[31:0]` + `rs2_i`.
- R9: With `op_i` = 11, the result is zero-extended `rs1_i[31:0]` shifted left by the bit position. Bits that pass beyond bit 63 are lost, so the copied field is min(32, 64 - position) wide, and every other bit is 0.
- R10: Every sum wraps modulo 2^64, and there is no carry output.
- R11: Codes 12 to 15 on `op_i` give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rs1_i | input | 64 | First operand |
| rs2_i | input | 64 | Second operand; low six bits can give the bit position |
| imm_i | input | 6 | Immediate bit position / shift amount |
| imm_sel_i | input | 1 | 1 selects `imm_i` as the position, 0 selects `rs2_i[5:0]` |
| op_i | input | 4 | Operation code |
| res_o | output | 64 | Result |

## Verification
The bit operations are driven at positions 0, 32 and 63, with all-zero and all-one operands. They are also driven with a position register whose upper bits are junk, which shows whether bits above 5 leak into the index. A full sweep of clear and extract over all 64 positions catches any single wrong mask bit. The scaled adds use first operands with bits set in 63:32 and near the top, so each case tells a full-width shift apart from a zero-extended word and shows whether carries wrap. The unsigned-word shift is tried at 0, 4 and 40, and the case at 40 shows whether the field is cut off at bit 63.

// File: rtl/bitop_scaled_add.sv
module bitop_scaled_add #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [XLEN-1:0]         rs1_i,
  input  logic [XLEN-1:0]         rs2_i,
  input  logic [$clog2(XLEN)-1:0] imm_i,
  input  logic                    imm_sel_i,
  input  logic [3:0]              op_i,
  output logic [XLEN-1:0]         res_o
);
  localparam int IW = $clog2(XLEN);

  localparam logic [3:0] OP_SET  = 4'd0;
  localparam logic [3:0] OP_CLR  = 4'd1;
  localparam logic [3:0] OP_FLIP = 4'd2;
  localparam logic [3:0] OP_EXT  = 4'd3;
  localparam logic [3:0] OP_SA1  = 4'd4;
  localparam logic [3:0] OP_SA2  = 4'd5;
  localparam logic [3:0] OP_SA3  = 4'd6;
  localparam logic [3:0] OP_SA1W = 4'd7;
  localparam logic [3:0] OP_SA2W = 4'd8;
  localparam logic [3:0] OP_SA3W = 4'd9;
  localparam logic [3:0] OP_ADDW = 4'd10;
  localparam logic [3:0] OP_SLLW = 4'd11;

  logic [IW-1:0]   idx;
  logic [XLEN-1:0] mask;
  logic [XLEN-1:0] word;
  logic [XLEN-1:0] base;
  logic [1:0]      scale;

  assign idx  = imm_sel_i ? imm_i : rs2_i[IW-1:0];
  assign mask = {{(XLEN-1){1'b0}}, 1'b1} << idx;
  assign word = {{(XLEN-WLEN){1'b0}}, rs1_i[WLEN-1:0]};

  always_comb begin
    base  = rs1_i;
    scale = 2'd0;
    unique case (op_i)
      OP_SA1:  scale = 2'd1;
      OP_SA2:  scale = 2'd2;
      OP_SA3:  scale = 2'd3;
      OP_SA1W: begin base = word; scale = 2'd1; end
      OP_SA2W: begin base = word; scale = 2'd2; end
      OP_SA3W: begin base = word; scale = 2'd3; end
      OP_ADDW: base = word;
      default: ;
    endcase
  end

  always_comb begin
    unique case (op_i)
      OP_SET:  res_o = rs1_i | mask;
      OP_CLR:  res_o = rs1_i & ~mask;
      OP_FLIP: res_o = rs1_i ^ mask;
      OP_EXT:  res_o = {{(XLEN-1){1'b0}}, rs1_i[idx]};
      OP_SA1, OP_SA2, OP_SA3, OP_SA1W, OP_SA2W, OP_SA3W, OP_ADDW:
               res_o = (base << scale) + rs2_i;
      OP_SLLW: res_o = word << idx;
      default: res_o = '0;
    endcase
  end

  always_comb begin
    if (op_i == OP_SET)
      a_r2_set_bit_high: assert (res_o[idx] == 1'b1) else $error("set bit not high");
    if (op_i == OP_CLR)
      a_r3_clr_bit_low: assert (res_o[idx] == 1'b0) else $error("cleared bit not low");
    if (op_i == OP_FLIP)
      a_r4_flip_one_bit: assert ($countones(res_o ^ rs1_i) == 1) else $error("flip changed wrong bit count");
    if (op_i == OP_EXT)
      a_r5_ext_upper_zero: assert (res_o[XLEN-1:1] == '0) else $error("extract upper bits nonzero");
    if (op_i == OP_SLLW)
      a_r9_sllw_low_zero: assert ((res_o & ((({{(XLEN-1){1'b0}}, 1'b1}) << idx) - 1'b1)) == '0)
        else $error("shifted word has low bits set");
    if (op_i > OP_SLLW)
      a_r11_unused_zero: assert (res_o == '0) else $error("unused code gave nonzero result");
  end
endmodule

// File: tb/bitop_scaled_add_tb.sv
module bitop_scaled_add_tb_top;
  logic        clk = 1'b0;
  logic [63:0] rs1, rs2, res;
  logic [5:0]  imm;
  logic        isel;
  logic [3:0]  op;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  bitop_scaled_add dut_i (
    .rs1_i(rs1), .rs2_i(rs2), .imm_i(imm), .imm_sel_i(isel), .op_i(op), .res_o(res)
  );

  localparam int NV = 17;
  localparam logic [3:0]  V_OP  [NV] = '{4'd0, 4'd0, 4'd1, 4'd2, 4'd3, 4'd3, 4'd4, 4'd5, 4'd6,
                                         4'd7, 4'd8, 4'd9, 4'd10, 4'd11, 4'd11, 4'd11, 4'd15};
  localparam logic        V_SEL [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0,
                                         1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic [5:0]  V_IMM [NV] = '{6'd5, 6'd0, 6'd9, 6'd32, 6'd63, 6'd0, 6'd0, 6'd0, 6'd0,
                                         6'd0, 6'd0, 6'd0, 6'd0, 6'd40, 6'd0, 6'd4, 6'd0};
  localparam logic [63:0] V_A   [NV] = '{
    64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF,
    64'h8000_0000_0000_0000, 64'h0123_4567_89AB_CDEF,
    64'h8000_0000_0000_0001, 64'h10, 64'hFFFF_FFFF_FFFF_FFFF,
    64'hFFFF_FFFF_8000_0000, 64'h1234_5678_FFFF_FFFF, 64'hAAAA_AAAA_0000_0010,
    64'hDEAD_BEEF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0009_8765_4321,
    64'hFFFF_FFFF_1234_5678, 64'hFFFF_FFFF_FFFF_FFFF};
  localparam logic [63:0] V_B   [NV] = '{
    64'h3F, 64'h3F, 64'hFFFF_FFFF_FFFF_FF44, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFC4,
    64'h5, 64'h3, 64'h8, 64'h1, 64'h0, 64'h100, 64'hFFFF_FFFF_0000_0001,
    64'h0, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF};
  localparam logic [63:0] V_EXP [NV] = '{
    64'h8000_0000_0000_0000, 64'h1, 64'hFFFF_FFFF_FFFF_FFEF, 64'h0123_4566_89AB_CDEF,
    64'h1, 64'h0, 64'h7, 64'h43, 64'h0,
    64'h0000_0001_0000_0001, 64'h0000_0003_FFFF_FFFC, 64'h180,
    64'h0, 64'hFFFF_FF00_0000_0000, 64'h8765_4321, 64'h0000_0001_2345_6780, 64'h0};
  localparam string       V_TAG [NV] = '{
    "R2", "R1", "R3", "R4", "R5", "R1", "R6", "R6", "R10",
    "R7", "R7", "R7", "R8", "R9", "R9", "R9", "R11"};

  task automatic apply(input logic [3:0] o, input logic s, input logic [5:0] i,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] exp, input string tag);
    @(negedge clk);
    op = o; isel = s; imm = i; rs1 = a; rs2 = b;
    #2;
    n_run++;
    if (res !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d got %h expected %h", tag, o, res, exp);
    end
  endtask

  initial begin
    op = 4'd12; isel = 1'b0; imm = '0; rs1 = '0; rs2 = '0;
    repeat (2) @(posedge clk);
    // R11 idle state: unused code with zero operands gives zero
    apply(4'd12, 1'b0, 6'd0, 64'h0, 64'h0, 64'h0, "R11");
    for (int k = 0; k < NV; k++)
      apply(V_OP[k], V_SEL[k], V_IMM[k], V_A[k], V_B[k], V_EXP[k], V_TAG[k]);
    // R3 sweep every position of clear through the register index
    for (int p = 0; p < 64; p++)
      apply(4'd1, 1'b0, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hABCD_0000_0000_0000 | 64'(p),
            ~(64'h1 << p), "R3");
    // R5 sweep extract through the immediate on a single-one pattern
    for (int p = 0; p < 64; p++)
      apply(4'd3, 1'b1, 6'(p), 64'h0000_0100_0000_0000, 64'h0,
            (p == 40) ? 64'h1 : 64'h0, "R5");
    // R1 immediate ignored when select is low
    apply(4'd2, 1'b0, 6'd17, 64'h0, 64'h1, 64'h2, "R1");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule